// File: doc/BRIEF.md
# Reset configuration word fetcher

At hard reset this block pulls a set of 32-bit configuration words out of a boot memory, one byte at a time. One word is for the device that contains the block (the master word). Up to seven more go to slave devices that share the boot memory. When the fetch finishes, the block presents the master word and a flat array of slave words, each with a valid flag. It also drives a reset-vector address whose base is chosen by one bit of the master word.

Every byte comes from an address on a 64-bit boundary, and it is taken from one fixed 8-bit lane of the memory data bus: the most significant byte lane. The assembled words are therefore the same whatever width the boot device has. Reads use a request/acknowledge handshake, and the memory may take any number of cycles to answer, up to a limit. If one read waits longer than that limit, the fetch stops and an error flag is raised.

Top module: `rstcfg_fetch`

## Requirements
- R1: After reset is released the block makes exactly (N_SLAVES+1)*4 reads (32 by default) and then never raises rd_req again until the next reset.
- R2: Read number k (counting from 0) presents rd_addr = 8*k, so every address has its three low bits at zero.
- R3: A byte is taken from rd_lane only on a clock edge where rd_req and rd_ack are both high; the lane value at any other time has no effect on the words.
- R4: Reads 4w to 4w+3 build word w, with read 4w placed in bits 31:24 and read 4w+3 in bits 7:0.
- R5: Word 0 is driven on master_word; word n (n = 1..N_SLAVES) is driven on slave_words[32n-1:32(n-1)].
- R6: master_valid and slave_valid[n-1] go high on the edge that captures the fourth byte of their word. They do not go low again before reset. A word with fewer than four bytes captured stays flagged invalid.
- R7: rd_req stays high with rd_addr unchanged until the edge on which rd_ack is sampled high. rd_req is then low for at least one cycle before the next read.
- R8: fetch_done is high for exactly one cycle, starting at the edge that captures the last byte. After that the word outputs, the valid flags and reset_vector do not change until reset.
- R9: If rd_req has been high for ACK_LIMIT consecutive edges with no rd_ack, that edge drops rd_req and sets fetch_err. fetch_err then stays set and fetch_done never rises. Words and flags captured before the stall are kept. A read answered after ACK_LIMIT-1 waiting edges still completes normally.
- R10: reset_vector is 0xFFF00100 when master_word[BASE_SEL_BIT] is 1 and 0x00000100 when it is 0 (default BASE_SEL_BIT = 20).
- R11: While reset is asserted, rd_req, fetch_done, fetch_err, all valid flags and all word bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| rd_req | output | 1 | Read request to the boot memory |
| rd_addr | output | ADDR_W | Byte address of the current read |
| rd_ack | input | 1 | Read acknowledge; rd_lane is valid while this is high |
| rd_lane | input | 8 | The most significant byte lane of the boot memory data bus |
| master_word | output | 32 | Configuration word for the local device |
| master_valid | output | 1 | master_word is complete |
| slave_words | output | N_SLAVES*32 | Slave words, slave 1 in the low 32 bits |
| slave_valid | output | N_SLAVES | Per-slave completion flags, bit n-1 for slave n |
| reset_vector | output | 32 | Reset exception address chosen by the master word |
| fetch_done | output | 1 | One-cycle pulse when all words are captured |
| fetch_err | output | 1 | Sticky flag: a read was not acknowledged in time |

## Verification
A byte that arrives with rd_ack shows up on the word outputs, and on its valid flag when it completes a word, right after the edge that samples the acknowledge. fetch_done follows the same rule and lasts one cycle. A new request appears one edge after the cycle in which rd_req was low. A stalled read sets fetch_err on the ACK_LIMIT-th edge that passes without an acknowledge. The bench drives the memory model and samples every output on the falling clock edge, so each check sees a value that is settled, half a cycle after the rising edge that produced it. Latency is swept from zero up to exactly one edge below the limit and one edge at it. Fetches are cut off just before and just after a slave word completes, to pin down when each flag rises.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;

  // Sequencer states of the fetch engine.
  typedef enum logic [1:0] {
    ST_ISSUE = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DONE  = 2'd2,
    ST_ABORT = 2'd3
  } fetch_state_e;

  localparam logic [31:0] VEC_BASE_LOW  = 32'h0000_0000;
  localparam logic [31:0] VEC_BASE_HIGH = 32'hFFF0_0000;
  localparam logic [31:0] VEC_RESET_OFS = 32'h0000_0100;

  // Reset exception address for a given base-select bit value.
  function automatic logic [31:0] reset_addr(input logic high_base);
    return (high_base ? VEC_BASE_HIGH : VEC_BASE_LOW) + VEC_RESET_OFS;
  endfunction

endpackage

// File: rtl/rstcfg_rsync.sv
// Asynchronous assert, synchronous release of the block's reset.
module rstcfg_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/rstcfg_seq.sv
// Read sequencer: address generation, handshake and acknowledge timeout.
module rstcfg_seq
  import rstcfg_pkg::*;
#(
  parameter int TOTAL_READS = 32,
  parameter int ADDR_W      = 32,
  parameter int STRIDE      = 8,
  parameter int ACK_LIMIT   = 1024,
  localparam int IDX_W      = $clog2(TOTAL_READS),
  localparam int WCNT_W     = $clog2(ACK_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              fetch_done,
  output logic              fetch_err
);

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(TOTAL_READS - 1);
  localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(ACK_LIMIT - 1);

  fetch_state_e      state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              req_q, req_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    addr_d  = addr_q;
    addr_en = 1'b0;
    req_d   = req_q;
    wcnt_d  = wcnt_q;
    done_d  = 1'b0;
    err_d   = err_q;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_ISSUE: begin
        req_d   = 1'b1;
        addr_en = 1'b1;
        addr_d  = ADDR_W'(idx_q) * ADDR_W'(STRIDE);
        wcnt_d  = '0;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_ack) begin
          cap_en = 1'b1;
          req_d  = 1'b0;
          if (idx_q == LAST_IDX) begin
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            idx_en  = 1'b1;
            idx_d   = idx_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end else if (wcnt_q == WAIT_LAST) begin
          req_d   = 1'b0;
          err_d   = 1'b1;
          state_d = ST_ABORT;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_DONE:  state_d = ST_DONE;
      ST_ABORT: state_d = ST_ABORT;
      default:  state_d = ST_ABORT;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ISSUE;
      idx_q   <= '0;
      addr_q  <= '0;
      req_q   <= 1'b0;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idx_en)  idx_q  <= idx_d;
      if (addr_en) addr_q <= addr_d;
      req_q   <= req_d;
      wcnt_q  <= wcnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign rd_req     = req_q;
  assign rd_addr    = addr_q;
  assign cap_idx    = idx_q;
  assign fetch_done = done_q;
  assign fetch_err  = err_q;

endmodule

// File: rtl/rstcfg_asm.sv
// Word assembly: one byte register per read slot, most significant byte first.
module rstcfg_asm #(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 32,
  localparam int BYTES  = WORD_W / 8,
  localparam int SLOTS  = N_WORDS * BYTES,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic [IDX_W-1:0]          cap_idx,
  input  logic [7:0]                cap_byte,
  output logic [N_WORDS*WORD_W-1:0] words,
  output logic [N_WORDS-1:0]        word_valid
);

  logic [SLOTS-1:0] slot_ld;

  // Decode the capture slot
  always_comb begin
    slot_ld = '0;
    if (cap_en) slot_ld[cap_idx] = 1'b1;
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   byte_q <= '0;
        else if (slot_ld[w*BYTES+b])  byte_q <= cap_byte;
      end
      // First read of the group lands in the top byte
      assign words[w*WORD_W + WORD_W - 1 - 8*b -: 8] = byte_q;
    end

    logic vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         vld_q <= 1'b0;
      else if (slot_ld[w*BYTES+BYTES-1])  vld_q <= 1'b1;
    end
    assign word_valid[w] = vld_q;
  end

endmodule

// File: rtl/rstcfg_vec.sv
// Reset vector select from one bit of the master word.
module rstcfg_vec
  import rstcfg_pkg::*;
(
  input  logic        base_sel,
  output logic [31:0] reset_vector
);

  always_comb begin
    reset_vector = reset_addr(base_sel);
  end

endmodule

// File: rtl/rstcfg_fetch.sv
module rstcfg_fetch #(
  parameter int N_SLAVES     = 7,
  parameter int ADDR_W       = 32,
  parameter int STRIDE       = 8,
  parameter int ACK_LIMIT    = 1024,
  parameter int BASE_SEL_BIT = 20,
  parameter int WORD_W       = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic                       rd_req,
  output logic [ADDR_W-1:0]          rd_addr,
  input  logic                       rd_ack,
  input  logic [7:0]                 rd_lane,
  output logic [WORD_W-1:0]          master_word,
  output logic                       master_valid,
  output logic [N_SLAVES*WORD_W-1:0] slave_words,
  output logic [N_SLAVES-1:0]        slave_valid,
  output logic [31:0]                reset_vector,
  output logic                       fetch_done,
  output logic                       fetch_err
);

  localparam int N_WORDS     = N_SLAVES + 1;
  localparam int BYTES       = WORD_W / 8;
  localparam int TOTAL_READS = N_WORDS * BYTES;
  localparam int IDX_W       = $clog2(TOTAL_READS);

  logic                      rst_n_sync;
  logic                      cap_en;
  logic [IDX_W-1:0]          cap_idx;
  logic [N_WORDS*WORD_W-1:0] words;
  logic [N_WORDS-1:0]        word_valid;

  rstcfg_rsync #(.STAGES(2)) u_rsync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  rstcfg_seq #(
    .TOTAL_READS (TOTAL_READS),
    .ADDR_W      (ADDR_W),
    .STRIDE      (STRIDE),
    .ACK_LIMIT   (ACK_LIMIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .rd_ack     (rd_ack),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .cap_en     (cap_en),
    .cap_idx    (cap_idx),
    .fetch_done (fetch_done),
    .fetch_err  (fetch_err)
  );

  rstcfg_asm #(
    .N_WORDS (N_WORDS),
    .WORD_W  (WORD_W)
  ) u_asm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cap_en     (cap_en),
    .cap_idx    (cap_idx),
    .cap_byte   (rd_lane),
    .words      (words),
    .word_valid (word_valid)
  );

  rstcfg_vec u_vec (
    .base_sel     (words[BASE_SEL_BIT]),
    .reset_vector (reset_vector)
  );

  assign master_word  = words[WORD_W-1:0];
  assign master_valid = word_valid[0];
  assign slave_words  = words[N_WORDS*WORD_W-1:WORD_W];
  assign slave_valid  = word_valid[N_WORDS-1:1];

endmodule

// File: rtl/rstcfg_fetch_chk.sv
module rstcfg_fetch_chk #(
  parameter int N_SLAVES     = 7,
  parameter int ADDR_W       = 32,
  parameter int STRIDE       = 8,
  parameter int ACK_LIMIT    = 1024,
  parameter int BASE_SEL_BIT = 20,
  parameter int WORD_W       = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_req,
  input logic [ADDR_W-1:0]          rd_addr,
  input logic                       rd_ack,
  input logic [WORD_W-1:0]          master_word,
  input logic                       master_valid,
  input logic [N_SLAVES*WORD_W-1:0] slave_words,
  input logic [N_SLAVES-1:0]        slave_valid,
  input logic [31:0]                reset_vector,
  input logic                       fetch_done,
  input logic                       fetch_err
);

  localparam int CW = $clog2(ACK_LIMIT + 1) + 1;

  logic [CW-1:0] stall_q;
  logic          seen_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q     <= '0;
      seen_done_q <= 1'b0;
    end else begin
      if (!rd_req || rd_ack) stall_q <= '0;
      else                   stall_q <= stall_q + 1'b1;
      if (fetch_done) seen_done_q <= 1'b1;
    end
  end

  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ((rd_addr & ADDR_W'(STRIDE - 1)) == '0));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (fetch_err || (rd_req && $stable(rd_addr))));

  p_gap_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> !rd_req);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !fetch_done);

  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done_q |-> (!rd_req && !fetch_done && $stable(master_word) && $stable(slave_words)
                     && $stable(slave_valid) && master_valid));

  p_valid_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((slave_valid & $past(slave_valid)) == $past(slave_valid)));

  p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> (!rd_req && !fetch_done));

  p_ack_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (stall_q < CW'(ACK_LIMIT)));

  p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_vector == (master_word[BASE_SEL_BIT] ? 32'hFFF0_0100 : 32'h0000_0100));

endmodule

bind rstcfg_fetch rstcfg_fetch_chk #(
  .N_SLAVES     (N_SLAVES),
  .ADDR_W       (ADDR_W),
  .STRIDE       (STRIDE),
  .ACK_LIMIT    (ACK_LIMIT),
  .BASE_SEL_BIT (BASE_SEL_BIT),
  .WORD_W       (WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req       (rd_req),
  .rd_addr      (rd_addr),
  .rd_ack       (rd_ack),
  .master_word  (master_word),
  .master_valid (master_valid),
  .slave_words  (slave_words),
  .slave_valid  (slave_valid),
  .reset_vector (reset_vector),
  .fetch_done   (fetch_done),
  .fetch_err    (fetch_err)
);

// File: tb/rstcfg_fetch_bench.sv
`timescale 1ns/1ps
module rstcfg_fetch_bench;

  localparam int ACK_LIM = 16;
  localparam int N_SL    = 7;
  localparam int NR      = (N_SL + 1) * 4;
  localparam int SEL     = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                 rd_req;
  logic [31:0]          rd_addr;
  logic                 rd_ack = 1'b0;
  logic [63:0]          bus = '0;
  logic [31:0]          mword;
  logic                 mvalid;
  logic [N_SL*32-1:0]   swords;
  logic [N_SL-1:0]      svalid;
  logic [31:0]          rvec;
  logic                 done, err;

  rstcfg_fetch #(.ACK_LIMIT(ACK_LIM), .BASE_SEL_BIT(SEL)) u_rstcfg_fetch (
    .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_addr (rd_addr),
    .rd_ack (rd_ack), .rd_lane (bus[63:56]), .master_word (mword),
    .master_valid (mvalid), .slave_words (swords), .slave_valid (svalid),
    .reset_vector (rvec), .fetch_done (done), .fetch_err (err)
  );

  logic [7:0] mem [NR];
  int lat_cfg = 0;
  int stall_at = -1;
  int ack_count, wait_cnt, addr_err, gap_err, done_seen;
  logic [7:0] junk = 8'h3C;
  int n_chk = 0, n_bad = 0, cycles = 0;

  // Boot memory model on a 64-bit bus; only the top lane reaches the block.
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack = 1'b0; wait_cnt = 0; ack_count = 0; addr_err = 0; gap_err = 0; done_seen = 0;
    end else begin
      junk = junk * 8'd5 + 8'd1;
      if (rd_ack) begin
        rd_ack = 1'b0;
        bus = {junk, ~junk, 48'h0};
        if (rd_req) gap_err++;
      end else if (rd_req) begin
        if (stall_at >= 0 && ack_count == stall_at) begin
          wait_cnt++;
        end else if (wait_cnt >= lat_cfg) begin
          int ix;
          ix = (rd_addr < 32'(NR * 8)) ? int'(rd_addr[7:3]) : 0;
          if (rd_addr != 32'(ack_count * 8)) addr_err++;
          bus = {mem[ix], {7{~mem[ix]}}};
          rd_ack = 1'b1;
          ack_count++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
          bus = {junk, 56'h0};
        end
      end else begin
        wait_cnt = 0;
        bus = {junk, 56'h0};
      end
      if (done) done_seen++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w);
    return {mem[4*w], mem[4*w+1], mem[4*w+2], mem[4*w+3]};
  endfunction

  function automatic logic [31:0] exp_vec();
    logic [31:0] m;
    m = exp_word(0);
    return m[SEL] ? 32'hFFF0_0100 : 32'h0000_0100;
  endfunction

  // Fill memory, hold reset, check reset state (R11), release.
  task automatic start_run(input int seed, input int lat, input int stall, input int fbit);
    int bi, bp;
    for (int i = 0; i < NR; i++) mem[i] = 8'(i * 29 + seed * 53 + 7);
    bi = (31 - SEL) / 8;
    bp = SEL % 8;
    if (fbit == 1) mem[bi][bp] = 1'b1;
    if (fbit == 2) mem[bi][bp] = 1'b0;
    lat_cfg = lat;
    stall_at = stall;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rd_req && !done && !err, "R11 ctrl", {29'b0, rd_req, done, err}, 32'h0);
    chk(mword == 0 && !mvalid, "R11 master", mword, 32'h0);
    chk(swords == '0 && svalid == '0, "R11 slaves", 32'(svalid), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_fetch(input int seed, input int lat, input int fbit);
    int n;
    bit got;
    logic [N_SL*32-1:0] snap;
    start_run(seed, lat, -1, fbit);
    got = 0;
    n = 0;
    while (!got && !err && n < 3000) begin
      @(negedge clk);
      if (done) got = 1;
      n++;
    end
    chk(got, "R8 done seen", 32'(got), 32'h1);
    chk(err == 1'b0, "R9 no error at latency", 32'(err), 32'h0);
    chk(mword == exp_word(0), "R4/R3 master word", mword, exp_word(0));
    for (int s = 1; s <= N_SL; s++)
      chk(swords[32*(s-1) +: 32] == exp_word(s), "R5 slave word", swords[32*(s-1) +: 32], exp_word(s));
    chk(mvalid && svalid == '1, "R6 all valid", 32'(svalid), 32'h7F);
    chk(rvec == exp_vec(), "R10 vector", rvec, exp_vec());
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 32'(done), 32'h0);
    snap = swords;
    repeat (20) @(negedge clk);
    chk(ack_count == NR && !rd_req, "R1 read count", 32'(ack_count), 32'(NR));
    chk(addr_err == 0, "R2 addresses", 32'(addr_err), 32'h0);
    chk(gap_err == 0, "R7 gap after ack", 32'(gap_err), 32'h0);
    chk(swords == snap && mword == exp_word(0) && done_seen == 1, "R8 stable after done",
        32'(done_seen), 32'h1);
  endtask

  // Memory stops answering at read number 'stall'.
  task automatic t_abort(input int stall, input logic [N_SL-1:0] exp_sv, input bit exp_mv);
    int n;
    start_run(stall + 3, 1, stall, 0);
    n = 0;
    while (!err && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(err == 1'b1, "R9 error raised", 32'(err), 32'h1);
    repeat (20) @(negedge clk);
    chk(err && !rd_req && done_seen == 0, "R9 sticky and silent", {30'b0, err, rd_req}, 32'h2);
    chk(ack_count == stall, "R9 no reads after abort", 32'(ack_count), 32'(stall));
    chk(svalid == exp_sv && mvalid == exp_mv, "R6 partial valid", 32'(svalid), 32'(exp_sv));
    if (exp_mv) chk(mword == exp_word(0), "R9 master kept", mword, exp_word(0));
    if (exp_sv[0]) chk(swords[31:0] == exp_word(1), "R9 slave 1 kept", swords[31:0], exp_word(1));
  endtask

  task automatic t_limit_exceeded();
    int n;
    start_run(9, ACK_LIM, -1, 0);
    n = 0;
    while (!err && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(err == 1'b1, "R9 limit exceeded", 32'(err), 32'h1);
    chk(ack_count == 0 && !rd_req && !mvalid, "R9 stopped at first read", 32'(ack_count), 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    t_fetch(1, 0, 1);            // zero latency, high base (R10)
    t_fetch(2, 3, 2);            // short latency, low base (R10)
    t_fetch(5, ACK_LIM - 1, 0);  // one edge under the limit (R9)
    t_limit_exceeded();          // one edge at the limit (R9)
    t_abort(7, 7'b0000000, 1'b1); // slave 1 missing its last byte (R6)
    t_abort(8, 7'b0000001, 1'b1); // slave 1 just complete (R6)
    t_abort(2, 7'b0000000, 1'b0); // master incomplete (R6)
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule